// File: doc/BRIEF.md
# Trapping Integer Execute Unit

This block is the purely combinational integer datapath of a 32-bit load/store core's execute stage. Each cycle it takes two register values, a raw 16-bit immediate field, a 5-bit constant shift count and an operation code. It returns a result word, a flag saying whether the destination register may be written, a flag that raises an arithmetic overflow exception, and a flag for an operation code it does not know.

The operations are add and subtract, each in a trapping and a wrapping form, plus immediate variants. It also covers the four bitwise functions with register operands, three of them with an immediate operand, the load-upper-immediate form, constant and register-controlled shifts in three flavours, and signed and unsigned compare-and-set. Immediate handling depends on the operation: arithmetic and compare forms sign-extend the field, and bitwise forms zero-extend it. A trapping overflow still presents the wrapped sum on `result`, but it holds `wr_en` low so the pipeline can discard it and take the exception.

Top module: `xu_int_exec`

## Requirements
- R1: ADD (code 0, a+b) and ADDI (code 4, a+sign-extended imm) set `ovf_trap`=1 and `wr_en`=0 when both addends carry the same sign and the sum's sign differs from it; `result` still shows the wrapped sum. Otherwise `wr_en`=1, `ovf_trap`=0 and `result` is the sum.
- R2: SUB (code 2, a-b) sets `ovf_trap`=1 and `wr_en`=0 when the operand signs differ and the sign of the difference differs from that of a; otherwise it writes the difference.
- R3: ADDU (1), SUBU (3) and ADDIU (5) wrap modulo 2^32, always assert `wr_en` and never assert `ovf_trap`.
- R4: ADDI, ADDIU, SLTI (22) and SLTIU (23) extend `imm` by copying bit 15 into bits 31:16. SLTIU then compares that extended pattern as unsigned.
- R5: ANDI (10), ORI (11) and XORI (12) combine `opnd_a` with `imm` zero-extended to 32 bits.
- R6: LUI (13) returns `imm` in bits 31:16 and zeros in bits 15:0.
- R7: AND (6), OR (7), XOR (8) and NOR (9) combine `opnd_a` with `opnd_b` bitwise. NOR returns the inverse of the OR.
- R8: SLL (14), SRL (15) and SRA (16) shift `opnd_b` by `shamt`. SLLV (17), SRLV (18) and SRAV (19) shift `opnd_b` by bits 4:0 of `opnd_a` and ignore its upper bits.
- R9: Right arithmetic shifts fill vacated bits with bit 31 of the value. Right logical shifts fill them with zeros.
- R10: SLT (20), SLTU (21), SLTI (22) and SLTIU (23) return 1 when a is below the second operand and 0 otherwise. The signed forms use two's complement order, including across the overflow boundary, and the unsigned forms use plain binary order.
- R11: Codes 24 to 31 assert `illegal_op`, drive `result` to 0 and hold `wr_en` and `ovf_trap` low.
- R12: Every code from 0 to 23 keeps `illegal_op` low, and `ovf_trap` can rise only for codes 0, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First register operand (rs); also the variable shift count source |
| opnd_b | input | 32 | Second register operand (rt); the value that shifts act on |
| imm | input | 16 | Raw immediate field, extended per operation |
| shamt | input | 5 | Constant shift count |
| op_sel | input | 5 | Operation code |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Destination write permitted |
| ovf_trap | output | 1 | Signed overflow exception request |
| illegal_op | output | 1 | Unrecognised operation code |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 16-bit immediate, the behavioural adder and the log-staged shifter. In that build, the overflow checks at the two sign boundaries reach the shared subtract-based compare path, and the shift tests reach every stage of the staged shifter, since counts of 1, 3, 4 and 31 select each stage bit. Directed cases pin the trap edges such as 0x7FFFFFFF+1 and 0x80000000-1. A random sweep over all 24 legal codes is then compared against an arithmetic reference that detects overflow with 64-bit signed sums instead of sign bits.

// File: rtl/xu_pkg.sv
package xu_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
      OP_ADDI  = 5'd4,  OP_ADDIU = 5'd5,  OP_AND   = 5'd6,  OP_OR    = 5'd7,
      OP_XOR   = 5'd8,  OP_NOR   = 5'd9,  OP_ANDI  = 5'd10, OP_ORI   = 5'd11,
      OP_XORI  = 5'd12, OP_LUI   = 5'd13, OP_SLL   = 5'd14, OP_SRL   = 5'd15,
      OP_SRA   = 5'd16, OP_SLLV  = 5'd17, OP_SRLV  = 5'd18, OP_SRAV  = 5'd19,
      OP_SLT   = 5'd20, OP_SLTU  = 5'd21, OP_SLTI  = 5'd22, OP_SLTIU = 5'd23
   } xu_op_e;

   localparam int NUM_LEGAL_OPS = 24;

   typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} xu_logic_e;
   typedef enum logic [1:0] {SH_LL, SH_RL, SH_RA} xu_shift_e;
   typedef enum logic [2:0] {SRC_ADD, SRC_LOGIC, SRC_SHIFT, SRC_LESS, SRC_UPPER, SRC_NONE} xu_src_e;
endpackage

// File: rtl/xu_addsub.sv
module xu_addsub #(
   parameter int DATA_W = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              carry,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   assign b_eff = sub ? ~b : b;

   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] c;
         assign c[0] = sub;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
            assign c[i+1]   = (a[i] & b_eff[i]) | (c[i] & (a[i] ^ b_eff[i]));
         end
         assign carry = c[DATA_W];
      end else begin : g_behav
         logic [DATA_W:0] full;
         assign full  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
         assign sum   = full[MSB:0];
         assign carry = full[DATA_W];
      end
   endgenerate

   // same-sign inputs to the adder core, result sign flipped
   assign ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/xu_logic.sv
module xu_logic
   import xu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  xu_logic_e         kind,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (kind)
         LG_AND:  y = a & b;
         LG_OR:   y = a | b;
         LG_XOR:  y = a ^ b;
         default: y = ~(a | b);
      endcase
   end
endmodule

// File: rtl/xu_shift.sv
module xu_shift
   import xu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit STAGED = 1'b1,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] value,
   input  logic [SH_W-1:0]   amount,
   input  xu_shift_e         kind,
   output logic [DATA_W-1:0] y
);
   localparam int MSB = DATA_W - 1;

   generate
      if (STAGED) begin : g_staged
         logic              left;
         logic              fill;
         logic [DATA_W-1:0] rev_in;
         logic [DATA_W-1:0] rev_out;
         logic [DATA_W-1:0] st [SH_W+1];

         assign left = (kind == SH_LL);
         assign fill = (kind == SH_RA) & value[MSB];

         for (genvar i = 0; i < DATA_W; i++) begin : g_rev
            assign rev_in[i]  = value[MSB-i];
            assign rev_out[i] = st[SH_W][MSB-i];
         end

         assign st[0] = left ? rev_in : value;

         for (genvar s = 0; s < SH_W; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign st[s+1] = amount[s] ? {{STEP{fill}}, st[s][MSB:STEP]} : st[s];
         end

         assign y = left ? rev_out : st[SH_W];
      end else begin : g_behav
         always_comb begin
            case (kind)
               SH_LL:   y = value << amount;
               SH_RL:   y = value >> amount;
               SH_RA:   y = $unsigned($signed(value) >>> amount);
               default: y = value;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/xu_int_exec.sv
module xu_int_exec
   import xu_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int IMM_W          = 16,
   parameter bit RIPPLE_ADDER   = 1'b0,
   parameter bit STAGED_SHIFTER = 1'b1,
   localparam int SH_W          = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic [SH_W-1:0]   shamt,
   input  logic [OP_W-1:0]   op_sel,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              ovf_trap,
   output logic              illegal_op
);
   localparam int MSB   = DATA_W - 1;
   localparam int EXT_W = DATA_W - IMM_W;

   generate
      if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("xu_int_exec: DATA_W must be a power of two");
      end
      if (DATA_W < 2 * IMM_W) begin : g_bad_imm
         $error("xu_int_exec: DATA_W must hold two immediate fields");
      end
   endgenerate

   logic [DATA_W-1:0] imm_sx, imm_zx, upper;
   assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign imm_zx = {{EXT_W{1'b0}}, imm};
   assign upper  = {imm, {EXT_W{1'b0}}};

   // decoded controls
   logic [DATA_W-1:0] add_b, lg_b, sh_val;
   logic [SH_W-1:0]   sh_amt;
   logic              add_sub, trap_en, less_signed, legal;
   xu_logic_e         lg_kind;
   xu_shift_e         sh_kind;
   xu_src_e           src;

   always_comb begin
      add_b       = opnd_b;
      add_sub     = 1'b0;
      trap_en     = 1'b0;
      lg_b        = opnd_b;
      lg_kind     = LG_AND;
      sh_val      = opnd_b;
      sh_amt      = shamt;
      sh_kind     = SH_LL;
      less_signed = 1'b0;
      src         = SRC_NONE;
      legal       = 1'b1;
      case (op_sel)
         OP_ADD:   begin src = SRC_ADD; trap_en = 1'b1; end
         OP_ADDU:  begin src = SRC_ADD; end
         OP_SUB:   begin src = SRC_ADD; add_sub = 1'b1; trap_en = 1'b1; end
         OP_SUBU:  begin src = SRC_ADD; add_sub = 1'b1; end
         OP_ADDI:  begin src = SRC_ADD; add_b = imm_sx; trap_en = 1'b1; end
         OP_ADDIU: begin src = SRC_ADD; add_b = imm_sx; end
         OP_AND:   begin src = SRC_LOGIC; lg_kind = LG_AND; end
         OP_OR:    begin src = SRC_LOGIC; lg_kind = LG_OR; end
         OP_XOR:   begin src = SRC_LOGIC; lg_kind = LG_XOR; end
         OP_NOR:   begin src = SRC_LOGIC; lg_kind = LG_NOR; end
         OP_ANDI:  begin src = SRC_LOGIC; lg_kind = LG_AND; lg_b = imm_zx; end
         OP_ORI:   begin src = SRC_LOGIC; lg_kind = LG_OR;  lg_b = imm_zx; end
         OP_XORI:  begin src = SRC_LOGIC; lg_kind = LG_XOR; lg_b = imm_zx; end
         OP_LUI:   begin src = SRC_UPPER; end
         OP_SLL:   begin src = SRC_SHIFT; sh_kind = SH_LL; end
         OP_SRL:   begin src = SRC_SHIFT; sh_kind = SH_RL; end
         OP_SRA:   begin src = SRC_SHIFT; sh_kind = SH_RA; end
         OP_SLLV:  begin src = SRC_SHIFT; sh_kind = SH_LL; sh_amt = opnd_a[SH_W-1:0]; end
         OP_SRLV:  begin src = SRC_SHIFT; sh_kind = SH_RL; sh_amt = opnd_a[SH_W-1:0]; end
         OP_SRAV:  begin src = SRC_SHIFT; sh_kind = SH_RA; sh_amt = opnd_a[SH_W-1:0]; end
         OP_SLT:   begin src = SRC_LESS; add_sub = 1'b1; less_signed = 1'b1; end
         OP_SLTU:  begin src = SRC_LESS; add_sub = 1'b1; end
         OP_SLTI:  begin src = SRC_LESS; add_sub = 1'b1; add_b = imm_sx; less_signed = 1'b1; end
         OP_SLTIU: begin src = SRC_LESS; add_sub = 1'b1; add_b = imm_sx; end
         default:  begin legal = 1'b0; end
      endcase
   end

   // datapath
   logic [DATA_W-1:0] add_y, lg_y, sh_y;
   logic              add_c, add_v, less;

   xu_addsub #(.DATA_W(DATA_W), .RIPPLE(RIPPLE_ADDER)) u_add (
      .a(opnd_a), .b(add_b), .sub(add_sub), .sum(add_y), .carry(add_c), .ovf(add_v)
   );

   xu_logic #(.DATA_W(DATA_W)) u_logic (
      .a(opnd_a), .b(lg_b), .kind(lg_kind), .y(lg_y)
   );

   xu_shift #(.DATA_W(DATA_W), .STAGED(STAGED_SHIFTER)) u_shift (
      .value(sh_val), .amount(sh_amt), .kind(sh_kind), .y(sh_y)
   );

   // a - b: signed order from sign xor overflow, unsigned from borrow
   assign less = less_signed ? (add_y[MSB] ^ add_v) : ~add_c;

   always_comb begin
      case (src)
         SRC_ADD:   result = add_y;
         SRC_LOGIC: result = lg_y;
         SRC_SHIFT: result = sh_y;
         SRC_LESS:  result = {{(DATA_W-1){1'b0}}, less};
         SRC_UPPER: result = upper;
         default:   result = '0;
      endcase
   end

   assign ovf_trap   = legal & trap_en & add_v;
   assign wr_en      = legal & ~ovf_trap;
   assign illegal_op = ~legal;
endmodule

// File: rtl/xu_checker.sv
module xu_checker
   import xu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [OP_W-1:0]   op_sel,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic              ovf_trap,
   input logic              illegal_op
);
   localparam int EXT_W = DATA_W - IMM_W;

   always_comb begin
      if (ovf_trap) begin
         // R1
         trap_blocks_write_chk: assert (!wr_en);
         // R12
         trap_only_signed_chk: assert (op_sel == OP_ADD || op_sel == OP_SUB || op_sel == OP_ADDI);
      end
      if (illegal_op) begin
         // R11
         illegal_quiet_chk: assert (!wr_en && !ovf_trap && result == '0);
      end
      if (op_sel == OP_ADDU || op_sel == OP_SUBU || op_sel == OP_ADDIU) begin
         // R3
         no_overflow_chk: assert (!ovf_trap && wr_en);
      end
      if (op_sel == OP_SLT || op_sel == OP_SLTU || op_sel == OP_SLTI || op_sel == OP_SLTIU) begin
         // R10
         less_is_bit_chk: assert (result[DATA_W-1:1] == '0);
      end
      if (op_sel == OP_LUI) begin
         // R6
         upper_low_clear_chk: assert (result[EXT_W-1:0] == '0);
      end
      if (op_sel == OP_NOR) begin
         // R7
         nor_inverse_chk: assert (result == ~(opnd_a | opnd_b));
      end
      if (op_sel < OP_W'(NUM_LEGAL_OPS)) begin
         // R12
         legal_code_chk: assert (!illegal_op);
      end
   end
endmodule

bind xu_int_exec xu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
   .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result),
   .wr_en(wr_en), .ovf_trap(ovf_trap), .illegal_op(illegal_op)
);

// File: tb/sim_xu_int_exec.sv
module sim_xu_int_exec;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic [31:0] a = '0, b = '0;
   logic [15:0] im = '0;
   logic [4:0]  sh = '0;
   logic [4:0]  op = 5'd31;
   logic [31:0] result;
   logic        wr_en, ovf_trap, illegal_op;
   int          n_cmp = 0, n_bad = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xu_int_exec u0 (
      .opnd_a(a), .opnd_b(b), .imm(im), .shamt(sh), .op_sel(op),
      .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap), .illegal_op(illegal_op)
   );

   task automatic drive(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic [15:0] i, input logic [4:0] s);
      @(negedge clk);
      op = o; a = x; b = y; im = i; sh = s;
      #1;
   endtask

   task automatic expect_out(input string req, input logic [31:0] er, input logic ew,
                             input logic et, input logic ei);
      n_cmp++;
      if (result !== er || wr_en !== ew || ovf_trap !== et || illegal_op !== ei) begin
         n_bad++;
         $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d: got r=%h w=%b t=%b i=%b expected r=%h w=%b t=%b i=%b",
                  req, op, a, b, im, sh, result, wr_en, ovf_trap, illegal_op, er, ew, et, ei);
      end
   endtask

   task automatic vec(input string req, input logic [4:0] o, input logic [31:0] x,
                      input logic [31:0] y, input logic [15:0] i, input logic [4:0] s,
                      input logic [31:0] er, input logic ew, input logic et);
      drive(o, x, y, i, s);
      expect_out(req, er, ew, et, 1'b0);
   endtask

   // independent reference: overflow found with 64-bit signed sums
   task automatic ref_calc(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                           input logic [15:0] i, input logic [4:0] s,
                           output logic [31:0] r, output logic w, output logic t);
      logic [31:0] isx, izx;
      longint      wide;
      isx = {{16{i[15]}}, i};
      izx = {16'h0, i};
      r = '0; w = 1'b1; t = 1'b0;
      case (o)
         5'd0:  begin wide = longint'($signed(x)) + longint'($signed(y)); r = x + y; end
         5'd1:  r = x + y;
         5'd2:  begin wide = longint'($signed(x)) - longint'($signed(y)); r = x - y; end
         5'd3:  r = x - y;
         5'd4:  begin wide = longint'($signed(x)) + longint'($signed(isx)); r = x + isx; end
         5'd5:  r = x + isx;
         5'd6:  r = x & y;
         5'd7:  r = x | y;
         5'd8:  r = x ^ y;
         5'd9:  r = ~(x | y);
         5'd10: r = x & izx;
         5'd11: r = x | izx;
         5'd12: r = x ^ izx;
         5'd13: r = {i, 16'h0};
         5'd14: r = y << s;
         5'd15: r = y >> s;
         5'd16: r = $unsigned($signed(y) >>> s);
         5'd17: r = y << x[4:0];
         5'd18: r = y >> x[4:0];
         5'd19: r = $unsigned($signed(y) >>> x[4:0]);
         5'd20: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
         5'd21: r = (x < y) ? 32'd1 : 32'd0;
         5'd22: r = ($signed(x) < $signed(isx)) ? 32'd1 : 32'd0;
         5'd23: r = (x < isx) ? 32'd1 : 32'd0;
         default: begin r = '0; w = 1'b0; end
      endcase
      if (o == 5'd0 || o == 5'd2 || o == 5'd4) begin
         if (wide > 64'sd2147483647 || wide < -64'sd2147483648) begin
            t = 1'b1; w = 1'b0;
         end
      end
   endtask

   task automatic t_reset_state;
      #1;
      // R11: initial illegal code 31
      expect_out("R11 initial", 32'h0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_signed_add;
      vec("R1 max+1",      5'd0, 32'h7FFFFFFF, 32'h00000001, 16'h0, 5'd0, 32'h80000000, 1'b0, 1'b1);
      vec("R1 min+-1",     5'd0, 32'h80000000, 32'hFFFFFFFF, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b0, 1'b1);
      vec("R1 mixed",      5'd0, 32'h00000005, 32'hFFFFFFFD, 16'h0, 5'd0, 32'h00000002, 1'b1, 1'b0);
      vec("R1 addi max",   5'd4, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h80000000, 1'b0, 1'b1);
      vec("R1 addi min",   5'd4, 32'h80000000, 32'h0, 16'hFFFF, 5'd0, 32'h7FFFFFFF, 1'b0, 1'b1);
      vec("R1 addi neg",   5'd4, 32'h00000010, 32'h0, 16'hFFFF, 5'd0, 32'h0000000F, 1'b1, 1'b0);
   endtask

   task automatic t_signed_sub;
      vec("R2 min-1",      5'd2, 32'h80000000, 32'h00000001, 16'h0, 5'd0, 32'h7FFFFFFF, 1'b0, 1'b1);
      vec("R2 max--1",     5'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 5'd0, 32'h80000000, 1'b0, 1'b1);
      vec("R2 min-min",    5'd2, 32'h80000000, 32'h80000000, 16'h0, 5'd0, 32'h00000000, 1'b1, 1'b0);
      vec("R2 0-min",      5'd2, 32'h00000000, 32'h80000000, 16'h0, 5'd0, 32'h80000000, 1'b0, 1'b1);
   endtask

   task automatic t_unsigned_wrap;
      vec("R3 addu",       5'd1, 32'h7FFFFFFF, 32'h00000001, 16'h0, 5'd0, 32'h80000000, 1'b1, 1'b0);
      vec("R3 subu",       5'd3, 32'h00000000, 32'h00000001, 16'h0, 5'd0, 32'hFFFFFFFF, 1'b1, 1'b0);
      vec("R3 addiu",      5'd5, 32'hFFFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h00000000, 1'b1, 1'b0);
      vec("R3 addiu max",  5'd5, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 32'h80000000, 1'b1, 1'b0);
   endtask

   task automatic t_imm_extension;
      vec("R4 addiu sx",   5'd5,  32'h0, 32'h0, 16'h8000, 5'd0, 32'hFFFF8000, 1'b1, 1'b0);
      vec("R4 sltiu sx",   5'd23, 32'h5, 32'h0, 16'hFFFF, 5'd0, 32'h1, 1'b1, 1'b0);
      vec("R4 slti sx",    5'd22, 32'h5, 32'h0, 16'hFFFF, 5'd0, 32'h0, 1'b1, 1'b0);
      vec("R5 andi",       5'd10, 32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0, 32'h00008001, 1'b1, 1'b0);
      vec("R5 ori",        5'd11, 32'h12340000, 32'h0, 16'hABCD, 5'd0, 32'h1234ABCD, 1'b1, 1'b0);
      vec("R5 xori",       5'd12, 32'hFFFF0000, 32'h0, 16'hFFFF, 5'd0, 32'hFFFFFFFF, 1'b1, 1'b0);
      vec("R6 lui",        5'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hABCD, 5'd0, 32'hABCD0000, 1'b1, 1'b0);
   endtask

   task automatic t_bitwise;
      vec("R7 and", 5'd6, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 5'd0, 32'hF000F000, 1'b1, 1'b0);
      vec("R7 or",  5'd7, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 5'd0, 32'hFFF0FFF0, 1'b1, 1'b0);
      vec("R7 xor", 5'd8, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 5'd0, 32'h0FF00FF0, 1'b1, 1'b0);
      vec("R7 nor", 5'd9, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 5'd0, 32'h000F000F, 1'b1, 1'b0);
   endtask

   task automatic t_shifts;
      vec("R8 sll 31",     5'd14, 32'h0, 32'h00000001, 16'h0, 5'd31, 32'h80000000, 1'b1, 1'b0);
      vec("R8 sllv low5",  5'd17, 32'h00000023, 32'h00000001, 16'h0, 5'd0, 32'h00000008, 1'b1, 1'b0);
      vec("R8 srlv low5",  5'd18, 32'hFFFFFFE4, 32'h00000080, 16'h0, 5'd0, 32'h00000008, 1'b1, 1'b0);
      vec("R9 sra neg",    5'd16, 32'h0, 32'h80000000, 16'h0, 5'd4, 32'hF8000000, 1'b1, 1'b0);
      vec("R9 srl neg",    5'd15, 32'h0, 32'h80000000, 16'h0, 5'd4, 32'h08000000, 1'b1, 1'b0);
      vec("R9 srav 31",    5'd19, 32'h0000001F, 32'h80000000, 16'h0, 5'd0, 32'hFFFFFFFF, 1'b1, 1'b0);
      vec("R9 sra pos",    5'd16, 32'h0, 32'h40000000, 16'h0, 5'd1, 32'h20000000, 1'b1, 1'b0);
   endtask

   task automatic t_compare;
      vec("R10 slt -1<1",   5'd20, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h1, 1'b1, 1'b0);
      vec("R10 sltu -1<1",  5'd21, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 32'h0, 1'b1, 1'b0);
      vec("R10 slt min",    5'd20, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, 32'h1, 1'b1, 1'b0);
      vec("R10 sltu min",   5'd21, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, 32'h0, 1'b1, 1'b0);
      vec("R10 slt max",    5'd20, 32'h7FFFFFFF, 32'h80000000, 16'h0, 5'd0, 32'h0, 1'b1, 1'b0);
      vec("R10 slt equal",  5'd20, 32'h12345678, 32'h12345678, 16'h0, 5'd0, 32'h0, 1'b1, 1'b0);
   endtask

   task automatic t_illegal;
      drive(5'd24, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 5'd3);
      expect_out("R11 code 24", 32'h0, 1'b0, 1'b0, 1'b1);
      drive(5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 5'd7);
      expect_out("R11 code 31", 32'h0, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_random_sweep;
      logic [31:0] er;
      logic        ew, et;
      for (int k = 0; k < 1200; k++) begin
         logic [4:0]  o;
         logic [31:0] x, y;
         o = 5'($urandom_range(0, 23));
         x = $urandom;
         y = $urandom;
         if (k % 4 == 1) x = {x[31], 31'h7FFFFFFF} ^ {1'b0, 31'(k[0])};
         if (k % 4 == 2) y = (k % 8 == 2) ? 32'h80000000 : 32'h00000001;
         drive(o, x, y, 16'($urandom), 5'($urandom));
         ref_calc(o, x, y, im, sh, er, ew, et);
         // R12: every code 0..23 decodes as legal
         expect_out("R12 sweep", er, ew, et, 1'b0);
      end
   endtask

   initial begin
      t_reset_state();
      t_signed_add();
      t_signed_sub();
      t_unsigned_wrap();
      t_imm_extension();
      t_bitwise();
      t_shifts();
      t_compare();
      t_illegal();
      t_random_sweep();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule